// File: doc/BRIEF.md
# Bus Transfer Size and Burst Sequencer

This block drives the address phase of a 32-bit external bus. A requester hands it one transfer at a time: a byte address, a two-bit size code and a burst flag. The sequencer then presents one or more beats. Each beat carries the current address, a burst indicator, a two-bit transfer-size code, four byte-lane enables and a flag that says whether more data beats follow. The bus side acknowledges each beat. One cycle after the final acknowledge, the block raises a single-cycle `done` pulse.

A line burst covers the four-word line that holds the start address. It begins at the addressed word and climbs to the last word of the line without wrapping, so it lasts 4, 3, 2 or 1 beats. A single transfer that would straddle a word boundary is refused with a one-cycle `err` pulse, and no beat is issued. A request whose size code disagrees with its burst flag is refused the same way.

Back-pressure works in two places. On the request side, `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and a requester that sees `req_ready` low must keep its request. On the bus side, `beat_ack` acts as the ready for each beat. A beat stays on the outputs, unchanged, until an edge where `beat_valid` and `beat_ack` are both high.

Top module: `bus_xfer_seq`

## Requirements
- R1: Synchronous active-high `rst` sets `beat_valid`, `burst`, `more_beats`, `done`, `err`, `tsiz`, `be` and `bus_addr` to zero and sets `req_ready` to 1. This holds even when `rst` arrives in the middle of a burst.
- R2: `req_ready` is 1 exactly while no transfer is in progress. A request taken on an edge shows its first beat (`beat_valid`=1) in the next cycle. `req_valid` is ignored while `req_ready` is 0.
- R3: The size code is 00 byte, 01 half-word, 10 word, 11 line. On a single beat, `tsiz` is 01 for a byte, 10 for a half-word and 00 for a word.
- R4: On a single beat, `bus_addr` equals the request address. `be[i]` is set for byte offset i (i = `req_addr[1:0]` position), covering the lanes from the addressed offset upward for the number of bytes in the size.
- R5: On every burst beat, `burst`=1, `tsiz`=00, `be`=1111 and `bus_addr[1:0]`=00.
- R6: A burst starting at word w = `req_addr[3:2]` lasts 4−w beats. Each beat's address is 4 above the previous one, ending at word 3 of the line, with no wrap.
- R7: `more_beats` is 1 on every burst beat except the last. It is 0 on the last burst beat, on a one-beat burst and on every single beat.
- R8: The following requests are refused: burst flag set with a size other than line, line size with the burst flag clear, a half-word at offset 1 or 3, and a word at any non-zero offset. A refused request gives `err`=1 for one cycle, in the cycle after it is taken, with no beat and `req_ready` still 1.
- R9: A beat advances only on an edge with `beat_ack`=1 while `beat_valid`=1. Without that, all beat outputs hold. `beat_ack` while idle has no effect.
- R10: `done` is a single-cycle pulse in the cycle after the last acknowledged beat. In that cycle `beat_valid`, `burst`, `be`, `tsiz` and `bus_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 32 | Request byte address |
| req_size | input | 2 | Size code: 00 byte, 01 half, 10 word, 11 line |
| req_burst | input | 1 | Request is a line burst |
| bus_addr | output | 32 | Address of the current beat |
| burst | output | 1 | Current beat belongs to a burst |
| tsiz | output | 2 | Transfer-size code of the current beat |
| be | output | 4 | Byte-lane enables, bit i is byte offset i |
| more_beats | output | 1 | Further data beats follow this one |
| beat_valid | output | 1 | A beat is presented |
| beat_ack | input | 1 | Bus accepts the current beat |
| done | output | 1 | One-cycle pulse after the final beat |
| err | output | 1 | One-cycle pulse for a refused request |

## Verification
The assertions assume that `rst` is high from time zero until the first clock edges. They also assume that the only way a beat ends is an acknowledge or a reset. Nothing is assumed about the request inputs, which may change freely while the block is busy. The stimulus exercises this directly: during stalled beats it offers random junk requests and expects them to be ignored. It keeps `req_valid` low on the cycle of the final acknowledge, so the cycle that carries `done` starts from a quiet request port.

// File: rtl/bus_xfer_pkg.sv
package bus_xfer_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_LINE = 2'b11
  } size_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUS  = 1'b1
  } seq_state_e;

  localparam logic [1:0] TSIZ_FULL = 2'b00;
  localparam logic [1:0] TSIZ_ONE  = 2'b01;
  localparam logic [1:0] TSIZ_TWO  = 2'b10;
endpackage

// File: rtl/bxs_lane_mask.sv
module bxs_lane_mask #(
  parameter int LANES = 4,
  parameter int OFF_W = 2,
  parameter int CNT_W = 3
) (
  input  logic [OFF_W-1:0] off,
  input  logic [CNT_W-1:0] nbytes,
  output logic [LANES-1:0] mask
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask[i] = (int'(off) <= i) && (i < int'(off) + int'(nbytes));
  end
endmodule

// File: rtl/bxs_req_decode.sv
module bxs_req_decode
  import bus_xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LANES      = 4,
  parameter int LINE_WORDS = 4
) (
  input  logic [ADDR_W-1:0]                    addr,
  input  logic [1:0]                           size,
  input  logic                                 burst_req,
  output logic                                 legal,
  output logic [1:0]                           tsiz,
  output logic [LANES-1:0]                     lanes,
  output logic [$clog2(LINE_WORDS+1)-1:0]      beats,
  output logic [ADDR_W-1:0]                    start_addr
);
  localparam int OFF_W  = $clog2(LANES);
  localparam int WORD_W = $clog2(LINE_WORDS);
  localparam int CNT_W  = $clog2(LINE_WORDS + 1);
  localparam int BCW    = $clog2(LANES + 1);

  size_e            sz;
  logic [OFF_W-1:0] off;
  logic [WORD_W-1:0] word;
  logic [OFF_W-1:0] lane_off;
  logic [BCW-1:0]   nbytes;

  assign sz   = size_e'(size);
  assign off  = addr[OFF_W-1:0];
  assign word = addr[OFF_W +: WORD_W];

  always_comb begin
    legal      = 1'b0;
    tsiz       = TSIZ_FULL;
    nbytes     = '0;
    lane_off   = off;
    beats      = CNT_W'(1);
    start_addr = addr;
    if (burst_req) begin
      legal      = (sz == SZ_LINE);
      nbytes     = BCW'(LANES);
      lane_off   = '0;
      beats      = CNT_W'(LINE_WORDS) - CNT_W'(word);
      start_addr = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end else begin
      case (sz)
        SZ_BYTE: begin
          legal  = 1'b1;
          tsiz   = TSIZ_ONE;
          nbytes = BCW'(1);
        end
        SZ_HALF: begin
          legal  = (off[0] == 1'b0);
          tsiz   = TSIZ_TWO;
          nbytes = BCW'(2);
        end
        SZ_WORD: begin
          legal  = (off == '0);
          tsiz   = TSIZ_FULL;
          nbytes = BCW'(LANES);
        end
        default: legal = 1'b0;
      endcase
    end
  end

  bxs_lane_mask #(
    .LANES (LANES),
    .OFF_W (OFF_W),
    .CNT_W (BCW)
  ) u_mask (
    .off    (lane_off),
    .nbytes (nbytes),
    .mask   (lanes)
  );
endmodule

// File: rtl/bxs_beat_track.sv
module bxs_beat_track #(
  parameter int ADDR_W     = 32,
  parameter int LANES      = 4,
  parameter int LINE_WORDS = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                load,
  input  logic [ADDR_W-1:0]                   load_addr,
  input  logic [$clog2(LINE_WORDS+1)-1:0]     load_beats,
  input  logic                                step,
  input  logic                                clear,
  output logic [ADDR_W-1:0]                   cur_addr,
  output logic [$clog2(LINE_WORDS+1)-1:0]     remain,
  output logic                                last
);
  localparam int OFF_W  = $clog2(LANES);
  localparam int WORD_W = $clog2(LINE_WORDS);
  localparam int CNT_W  = $clog2(LINE_WORDS + 1);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cur_addr <= '0;
      remain   <= '0;
    end else if (load) begin
      cur_addr <= load_addr;
      remain   <= load_beats;
    end else if (step) begin
      cur_addr <= cur_addr + ADDR_W'(LANES);
      remain   <= remain - CNT_W'(1);
    end
  end

  assign last = (remain == CNT_W'(1));

  AST_STEP_ONE_WORD: assert property (@(posedge clk) disable iff (rst) (step && !clear && !load) |=> (cur_addr == $past(cur_addr) + ADDR_W'(LANES))); // R6
  AST_NO_LINE_WRAP: assert property (@(posedge clk) disable iff (rst) (step && !clear && !load) |=> (cur_addr[OFF_W +: WORD_W] > $past(cur_addr[OFF_W +: WORD_W]))); // R6
endmodule

// File: rtl/bus_xfer_seq.sv
module bus_xfer_seq
  import bus_xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LANES      = 4,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_burst,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              burst,
  output logic [1:0]        tsiz,
  output logic [LANES-1:0]  be,
  output logic              more_beats,
  output logic              beat_valid,
  input  logic              beat_ack,
  output logic              done,
  output logic              err
);
  localparam int OFF_W  = $clog2(LANES);
  localparam int WORD_W = $clog2(LINE_WORDS);
  localparam int CNT_W  = $clog2(LINE_WORDS + 1);

  seq_state_e        state_q;
  logic              burst_q;
  logic [1:0]        tsiz_q;
  logic [LANES-1:0]  be_q;
  logic              done_q;
  logic              err_q;

  logic              dec_legal;
  logic [1:0]        dec_tsiz;
  logic [LANES-1:0]  dec_lanes;
  logic [CNT_W-1:0]  dec_beats;
  logic [ADDR_W-1:0] dec_start;

  logic [CNT_W-1:0]  remain;
  logic              last_beat;
  logic              accept;
  logic              take;
  logic              fire;
  logic              finish;

  bxs_req_decode #(
    .ADDR_W     (ADDR_W),
    .LANES      (LANES),
    .LINE_WORDS (LINE_WORDS)
  ) u_dec (
    .addr       (req_addr),
    .size       (req_size),
    .burst_req  (req_burst),
    .legal      (dec_legal),
    .tsiz       (dec_tsiz),
    .lanes      (dec_lanes),
    .beats      (dec_beats),
    .start_addr (dec_start)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign take      = accept && dec_legal;
  assign fire      = (state_q == ST_BUS) && beat_ack;
  assign finish    = fire && last_beat;

  bxs_beat_track #(
    .ADDR_W     (ADDR_W),
    .LANES      (LANES),
    .LINE_WORDS (LINE_WORDS)
  ) u_track (
    .clk        (clk),
    .rst        (rst),
    .load       (take),
    .load_addr  (dec_start),
    .load_beats (dec_beats),
    .step       (fire && !last_beat),
    .clear      (finish),
    .cur_addr   (bus_addr),
    .remain     (remain),
    .last       (last_beat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      burst_q <= 1'b0;
      tsiz_q  <= '0;
      be_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= finish;
      err_q  <= accept && !dec_legal;
      if (take) begin
        state_q <= ST_BUS;
        burst_q <= req_burst;
        tsiz_q  <= dec_tsiz;
        be_q    <= dec_lanes;
      end else if (finish) begin
        state_q <= ST_IDLE;
        burst_q <= 1'b0;
        tsiz_q  <= '0;
        be_q    <= '0;
      end
    end
  end

  assign beat_valid = (state_q == ST_BUS);
  assign burst      = burst_q;
  assign tsiz       = tsiz_q;
  assign be         = be_q;
  assign done       = done_q;
  assign err        = err_q;
  assign more_beats = beat_valid && burst_q && (remain > CNT_W'(1));

  AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst) beat_valid |-> !req_ready); // R2
  AST_BURST_TSIZ_ZERO: assert property (@(posedge clk) disable iff (rst) burst |-> (tsiz == 2'b00 && be == {LANES{1'b1}} && bus_addr[OFF_W-1:0] == '0)); // R5
  AST_LAST_BEAT_NO_MORE: assert property (@(posedge clk) disable iff (rst) (burst && bus_addr[OFF_W +: WORD_W] == {WORD_W{1'b1}}) |-> !more_beats); // R7
  AST_ERR_NO_CYCLE: assert property (@(posedge clk) disable iff (rst) err |-> (!beat_valid && req_ready)); // R8
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst) (beat_valid && !beat_ack) |=> (beat_valid && $stable(bus_addr) && $stable(be) && $stable(tsiz) && $stable(burst))); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R10
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst) done |-> (!beat_valid && be == '0 && !burst && bus_addr == '0)); // R10
endmodule

// File: tb/tb_bus_xfer_seq.sv
module tb_bus_xfer_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_burst = 1'b0;
  logic [31:0] bus_addr;
  logic        burst;
  logic [1:0]  tsiz;
  logic [3:0]  be;
  logic        more_beats;
  logic        beat_valid;
  logic        beat_ack = 1'b0;
  logic        done;
  logic        err;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bus_xfer_seq dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_burst(req_burst),
    .bus_addr(bus_addr), .burst(burst), .tsiz(tsiz), .be(be),
    .more_beats(more_beats), .beat_valid(beat_valid), .beat_ack(beat_ack),
    .done(done), .err(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic logic exp_legal(input logic [31:0] a, input logic [1:0] sz, input logic bu);
    if (bu) return sz == 2'b11;
    case (sz)
      2'b00: return 1'b1;
      2'b01: return a[0] == 1'b0;
      2'b10: return a[1:0] == 2'b00;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] exp_tsiz(input logic [1:0] sz, input logic bu);
    if (bu) return 2'b00;
    case (sz)
      2'b00: return 2'b01;
      2'b01: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [3:0] exp_be(input logic [31:0] a, input logic [1:0] sz, input logic bu);
    int n;
    logic [3:0] m;
    if (bu) return 4'b1111;
    n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    m = '0;
    for (int i = 0; i < n; i++) m[int'(a[1:0]) + i] = 1'b1;
    return m;
  endfunction

  function automatic int exp_beats(input logic [31:0] a, input logic bu);
    return bu ? 4 - int'(a[3:2]) : 1;
  endfunction

  task automatic check_idle(input string tag);
    chk({tag, " beat_valid"}, beat_valid, 0);
    chk({tag, " burst"}, burst, 0);
    chk({tag, " be"}, be, 0);
    chk({tag, " tsiz"}, tsiz, 0);
    chk({tag, " bus_addr"}, bus_addr, 0);
    chk({tag, " more"}, more_beats, 0);
  endtask

  task automatic run_req(input logic [31:0] a, input logic [1:0] sz, input logic bu);
    logic lg;
    int nb;
    int stall;
    logic [31:0] st;
    lg = exp_legal(a, sz, bu);
    nb = exp_beats(a, bu);
    st = bu ? {a[31:2], 2'b00} : a;
    chk("R2 ready while idle", req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_burst = bu;
    @(negedge clk);
    req_valid = 1'b0; req_addr = $urandom; req_size = 2'($urandom); req_burst = 1'($urandom);
    if (!lg) begin
      chk("R8 err pulse", err, 1);
      chk("R8 no beat", beat_valid, 0);
      chk("R8 ready kept", req_ready, 1);
      @(negedge clk);
      chk("R8 err single cycle", err, 0);
      chk("R8 still idle", beat_valid, 0);
    end else begin
      chk("R8 no err on legal", err, 0);
      for (int k = 0; k < nb; k++) begin
        stall = $urandom_range(0, 2);
        for (int s = 0; s <= stall; s++) begin
          chk("R2 first beat next cycle / valid", beat_valid, 1);
          chk("R2 ready low while busy", req_ready, 0);
          chk(bu ? "R6 burst address" : "R4 single address", bus_addr, st + 32'(4 * k));
          chk(bu ? "R5 burst flag" : "R4 burst flag low", burst, bu);
          chk(bu ? "R5 burst tsiz" : "R3 single tsiz", tsiz, exp_tsiz(sz, bu));
          chk(bu ? "R5 burst lanes" : "R4 single lanes", be, exp_be(a, sz, bu));
          chk("R7 more beats", more_beats, bu && (k < nb - 1));
          chk("R10 no early done", done, 0);
          if (s == stall) begin
            beat_ack = 1'b1;
          end else begin
            beat_ack = 1'b0;
            req_valid = 1'($urandom);
            req_addr = $urandom;
            req_size = 2'($urandom);
            req_burst = 1'($urandom);
          end
          @(negedge clk);
          beat_ack = 1'b0;
          req_valid = 1'b0;
        end
      end
      chk("R10 done pulse", done, 1);
      check_idle("R10 quiet at done");
      chk("R10 ready at done", req_ready, 1);
      @(negedge clk);
      chk("R10 done single cycle", done, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h0000_5a17));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 after reset");
    chk("R1 done after reset", done, 0);
    chk("R1 err after reset", err, 0);
    chk("R1 ready after reset", req_ready, 1);

    beat_ack = 1'b1;
    @(negedge clk);
    beat_ack = 1'b0;
    check_idle("R9 idle ack ignored");
    chk("R9 idle ack no done", done, 0);

    for (int w = 0; w < 4; w++) run_req(32'h0000_1200 | 32'(w << 2) | 32'h3, 2'b11, 1'b1);
    for (int o = 0; o < 4; o++) run_req(32'h8000_0040 | 32'(o), 2'b00, 1'b0);
    run_req(32'h0000_0102, 2'b01, 1'b0);
    run_req(32'h0000_0100, 2'b01, 1'b0);
    run_req(32'h0000_0104, 2'b10, 1'b0);
    run_req(32'h0000_0101, 2'b01, 1'b0);
    run_req(32'h0000_0103, 2'b01, 1'b0);
    run_req(32'h0000_0106, 2'b10, 1'b0);
    run_req(32'h0000_0100, 2'b11, 1'b0);
    run_req(32'h0000_0100, 2'b00, 1'b1);
    run_req(32'hFFFF_FFF0, 2'b11, 1'b1);

    req_valid = 1'b1; req_addr = 32'h0000_2000; req_size = 2'b11; req_burst = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 burst running before reset", beat_valid, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_idle("R1 reset mid burst");
    chk("R1 ready after mid reset", req_ready, 1);
    @(negedge clk);

    for (int n = 0; n < 200; n++) begin
      logic [31:0] a;
      logic [1:0] sz;
      logic bu;
      a = $urandom;
      if ($urandom_range(0, 2) == 0) begin
        bu = 1'b1;
        sz = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b11;
      end else begin
        bu = 1'b0;
        sz = 2'($urandom);
      end
      run_req(a, sz, bu);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule